// File: doc/BRIEF.md
# Skewed Multi-Bank Ping-Pong Sample Buffer

This block holds two equal on-chip sample stores that alternate between two owners. The memory side owns one store and fills it through a wide write stream. The compute side owns the other store and reads it through P independent read ports, one for each parallel transform engine. A swap command exchanges the owners. The swap is held off until both sides have reported that their work on the current phase is finished.

Each store is cut into P banks. A sample's bank is chosen so that every burst-sized chunk of B samples starts one bank further on than the chunk before it. With this skew, P engines can fetch P neighbouring samples of one row in the same cycle, or the same offset from P successive chunks (column-stride order), without two engines ever hitting one bank. Every port can jump to an unrelated address on each cycle. Read data returns after a fixed latency of RD_LAT cycles, with a valid flag aligned to it.

The write stream follows valid/ready rules. A beat transfers on a cycle where both wr_valid and wr_ready are high. The memory side must hold wr_valid, wr_addr and wr_data steady while wr_ready is low. wr_ready falls only because the memory side has declared its fill finished, and it rises again at the swap. The read return path has no back-pressure: an engine that issues a read must accept the data RD_LAT cycles later.

Top module: `pp_skew_buffer`

## Requirements
- R1: After reset the memory side owns store 0 (fill_buf=0). Writes always land in store fill_buf and reads always come from the other store, so writing one store never changes data read from the other.
- R2: Sample address a sits in bank (a + floor(a/B)) mod P at word floor(a/P). This requires P, B and M to be powers of two and B to be a multiple of P. As a result, every address of a store keeps its own value.
- R3: A write beat carries W samples. Lane j (bits j*DW to j*DW+DW-1 of wr_data) is written to address A+j, where A is wr_addr with its low log2(W) bits cleared. The beat transfers only when wr_valid and wr_ready are both high.
- R4: Row-order reads are conflict-free and return correct data. In this pattern port k reads address r*P+k for any r, and all P ports are active in the same cycle.
- R5: Stride-order reads are conflict-free and return correct data. In this pattern port k reads address o+(c+k)*B for any offset o<B and first chunk c with c+P-1 < M/B, and all P ports are active in the same cycle.
- R6: A port may read a different, non-adjacent address on every cycle with no idle cycle between reads.
- R7: rd_valid[k] and rd_data[k] for a read issued on rd_en[k] appear exactly RD_LAT cycles later. rd_valid[k] is low in every other cycle.
- R8: A fill_done pulse drops wr_ready from the next cycle until the next swap. A beat offered while wr_ready is low is not written.
- R9: A swap_req is remembered, and busy is high, until both a fill_done and a calc_done have been seen since the last swap. The swap takes effect on the clock edge after both are present, or on the edge after swap_req if both were already present. At the swap, fill_buf toggles, busy falls and wr_ready returns high.
- R10: During and right after reset: fill_buf=0, busy=0, wr_ready=1, rd_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat can be accepted |
| wr_addr | input | log2(M) | Address of lane 0 (low bits ignored) |
| wr_data | input | W*DW | W samples, lane 0 in the low bits |
| rd_en | input | P | Per-port read request |
| rd_addr | input | P*log2(M) | Per-port sample address, port k at bits k*log2(M) |
| rd_valid | output | P | Per-port read data valid |
| rd_data | output | P*DW | Per-port read data, port k at bits k*DW |
| fill_done | input | 1 | Memory side finished its phase (pulse) |
| calc_done | input | 1 | Compute side finished its phase (pulse) |
| swap_req | input | 1 | Request to exchange store owners (pulse) |
| busy | output | 1 | Swap requested and still waiting |
| fill_buf | output | 1 | Index of the store the memory side owns |

## Verification
Read results are due RD_LAT cycles after the request, which is one cycle with the default setting. The bench works as a pipeline: on every falling edge it first compares the outputs with the expectation stored on the previous falling edge, then drives a new request and stores its expectation. Back-to-back reads are therefore checked with no gaps. wr_ready is due low one edge after the fill_done pulse. fill_buf is due to toggle one edge after the last of swap_req, fill_done and calc_done has been seen. The bench checks each control output on the falling edges that fall just before and just after the edge where the change is due.

// File: rtl/pp_skew_pkg.sv
package pp_skew_pkg;
  // Swap controller phase: idle, or holding a swap request until both sides report done.
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_WAIT = 1'b1
  } swap_st_e;
endpackage

// File: rtl/pp_skew_map.sv
// Skewed placement: bank = (addr + chunk) mod P, word = addr / P.
module pp_skew_map #(
  parameter int M = 64,
  parameter int P = 4,
  parameter int B = 8,
  localparam int AW = $clog2(M),
  localparam int PW = $clog2(P),
  localparam int BW = $clog2(B),
  localparam int WW = AW - PW
) (
  input  logic [AW-1:0] addr,
  output logic [PW-1:0] bank,
  output logic [WW-1:0] word
);
  logic [AW-1:0] chunk;
  assign chunk = addr >> BW;
  assign bank  = PW'(addr + chunk);
  assign word  = addr[AW-1:PW];
endmodule

// File: rtl/pp_bank_ram.sv
// One bank of one store: one write port, one registered read port.
module pp_bank_ram #(
  parameter int DEPTH  = 16,
  parameter int DW     = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_swap_ctrl.sv
// Ownership control: latches done flags, holds a swap request, toggles the fill store.
module pp_swap_ctrl
  import pp_skew_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fill_done,
  input  logic calc_done,
  input  logic swap_req,
  output logic busy,
  output logic fill_buf,
  output logic fill_locked
);
  swap_st_e st;
  logic     fill_f;
  logic     calc_f;
  logic     sel;
  logic     fire;

  assign fire = fill_f && calc_f && (swap_req || (st == SW_WAIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SW_IDLE;
      fill_f <= 1'b0;
      calc_f <= 1'b0;
      sel    <= 1'b0;
    end else if (fire) begin
      st     <= SW_IDLE;
      fill_f <= 1'b0;
      calc_f <= 1'b0;
      sel    <= ~sel;
    end else begin
      if (fill_done) fill_f <= 1'b1;
      if (calc_done) calc_f <= 1'b1;
      if (swap_req)  st     <= SW_WAIT;
    end
  end

  assign busy        = (st == SW_WAIT);
  assign fill_buf    = sel;
  assign fill_locked = fill_f;
endmodule

// File: rtl/pp_skew_buffer.sv
module pp_skew_buffer #(
  parameter int DW     = 16,
  parameter int M      = 64,
  parameter int P      = 4,
  parameter int B      = 8,
  parameter int W      = 2,
  parameter int RD_LAT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [$clog2(M)-1:0]    wr_addr,
  input  logic [W*DW-1:0]         wr_data,
  input  logic [P-1:0]            rd_en,
  input  logic [P*$clog2(M)-1:0]  rd_addr,
  output logic [P-1:0]            rd_valid,
  output logic [P*DW-1:0]         rd_data,
  input  logic                    fill_done,
  input  logic                    calc_done,
  input  logic                    swap_req,
  output logic                    busy,
  output logic                    fill_buf
);
  localparam int AW    = $clog2(M);
  localparam int PW    = $clog2(P);
  localparam int WW    = AW - PW;
  localparam int DEPTH = M / P;

  // ---------------- ownership control ----------------
  logic fill_locked;
  logic wr_fire;

  pp_swap_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_done   (fill_done),
    .calc_done   (calc_done),
    .swap_req    (swap_req),
    .busy        (busy),
    .fill_buf    (fill_buf),
    .fill_locked (fill_locked)
  );

  assign wr_ready = ~fill_locked;
  assign wr_fire  = wr_valid && wr_ready;

  // ---------------- write lanes -> banks ----------------
  logic [AW-1:0] wbase;
  logic [PW-1:0] wl_bank [W];
  logic [WW-1:0] wl_word [W];

  assign wbase = wr_addr & ~AW'(W - 1);

  for (genvar j = 0; j < W; j++) begin : g_wmap
    pp_skew_map #(.M(M), .P(P), .B(B)) u_wmap (
      .addr (wbase | AW'(j)),
      .bank (wl_bank[j]),
      .word (wl_word[j])
    );
  end

  logic [P-1:0]  bwe;
  logic [WW-1:0] bwaddr [P];
  logic [DW-1:0] bwdata [P];

  always_comb begin
    for (int b = 0; b < P; b++) begin
      bwe[b]    = 1'b0;
      bwaddr[b] = '0;
      bwdata[b] = '0;
      for (int j = 0; j < W; j++) begin
        if (wr_fire && (wl_bank[j] == PW'(b))) begin
          bwe[b]    = 1'b1;
          bwaddr[b] = wl_word[j];
          bwdata[b] = wr_data[j*DW +: DW];
        end
      end
    end
  end

  // ---------------- read ports -> banks ----------------
  logic [PW-1:0] rp_bank [P];
  logic [WW-1:0] rp_word [P];

  for (genvar k = 0; k < P; k++) begin : g_rmap
    pp_skew_map #(.M(M), .P(P), .B(B)) u_rmap (
      .addr (rd_addr[k*AW +: AW]),
      .bank (rp_bank[k]),
      .word (rp_word[k])
    );
  end

  logic [P-1:0]  bre;
  logic [WW-1:0] braddr [P];

  always_comb begin
    for (int b = 0; b < P; b++) begin
      bre[b]    = 1'b0;
      braddr[b] = '0;
      for (int k = 0; k < P; k++) begin
        if (rd_en[k] && (rp_bank[k] == PW'(b))) begin
          bre[b]    = 1'b1;
          braddr[b] = rp_word[k];
        end
      end
    end
  end

  // ---------------- two stores of P banks ----------------
  logic [DW-1:0] ram_q [2][P];

  for (genvar x = 0; x < 2; x++) begin : g_store
    for (genvar b = 0; b < P; b++) begin : g_bank
      pp_bank_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (bwe[b] && (fill_buf == 1'(x))),
        .waddr (bwaddr[b]),
        .wdata (bwdata[b]),
        .re    (bre[b] && (fill_buf != 1'(x))),
        .raddr (braddr[b]),
        .rdata (ram_q[x][b])
      );
    end
  end

  // ---------------- return path ----------------
  logic [P-1:0]    ren_q;
  logic            rsel_q;
  logic [PW-1:0]   rbank_q [P];
  logic [P*DW-1:0] s1_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ren_q  <= '0;
      rsel_q <= 1'b0;
      for (int k = 0; k < P; k++) rbank_q[k] <= '0;
    end else begin
      ren_q  <= rd_en;
      rsel_q <= ~fill_buf;
      for (int k = 0; k < P; k++) rbank_q[k] <= rp_bank[k];
    end
  end

  always_comb begin
    for (int k = 0; k < P; k++) begin
      s1_data[k*DW +: DW] = ren_q[k] ? ram_q[rsel_q][rbank_q[k]] : '0;
    end
  end

  if (RD_LAT == 1) begin : g_lat1
    assign rd_valid = ren_q;
    assign rd_data  = s1_data;
  end else begin : g_lat2
    logic [P-1:0]    v2_q;
    logic [P*DW-1:0] d2_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v2_q <= '0;
        d2_q <= '0;
      end else begin
        v2_q <= ren_q;
        d2_q <= s1_data;
      end
    end
    assign rd_valid = v2_q;
    assign rd_data  = d2_q;
  end
endmodule

// File: rtl/pp_skew_buffer_chk.sv
module pp_skew_buffer_chk #(
  parameter int M      = 64,
  parameter int P      = 4,
  parameter int B      = 8,
  parameter int RD_LAT = 1,
  localparam int AW    = $clog2(M)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [P-1:0]      rd_en,
  input logic [P*AW-1:0]   rd_addr,
  input logic [P-1:0]      rd_valid,
  input logic              wr_ready,
  input logic              busy,
  input logic              fill_buf
);
  // Per bank, which ports address it this cycle (bank worked out from the address).
  logic [P-1:0] hit [P];

  always_comb begin
    for (int b = 0; b < P; b++) begin
      for (int k = 0; k < P; k++) begin
        hit[b][k] = rd_en[k] &&
          ((((rd_addr[k*AW +: AW] % B) + (rd_addr[k*AW +: AW] / B)) % P) == b);
      end
    end
  end

  for (genvar b = 0; b < P; b++) begin : g_bank_chk
    // R4 and R5: never two ports on one bank
    p_no_bank_conflict_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit[b]) <= 1);
  end

  for (genvar k = 0; k < P; k++) begin : g_port_chk
    p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[k] |-> ##RD_LAT rd_valid[k]);
    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[k] |-> ##RD_LAT !rd_valid[k]);
  end

  p_busy_ends_in_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || !$stable(fill_buf)));

  p_swap_after_fill_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fill_buf) |-> ($past(!wr_ready) && wr_ready));

  p_reset_state_r10: assert property (@(posedge clk)
    !rst_n |=> (!fill_buf && !busy && wr_ready));
endmodule

bind pp_skew_buffer pp_skew_buffer_chk #(
  .M(M), .P(P), .B(B), .RD_LAT(RD_LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_valid (rd_valid),
  .wr_ready (wr_ready),
  .busy     (busy),
  .fill_buf (fill_buf)
);

// File: tb/tb_pp_skew_buffer.sv
module tb_pp_skew_buffer;
  localparam int DW = 16;
  localparam int M  = 64;
  localparam int P  = 4;
  localparam int B  = 8;
  localparam int W  = 2;
  localparam int AW = $clog2(M);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [AW-1:0]    wr_addr = '0;
  logic [W*DW-1:0]  wr_data = '0;
  logic [P-1:0]     rd_en = '0;
  logic [P*AW-1:0]  rd_addr = '0;
  logic [P-1:0]     rd_valid;
  logic [P*DW-1:0]  rd_data;
  logic             fill_done = 1'b0;
  logic             calc_done = 1'b0;
  logic             swap_req = 1'b0;
  logic             busy;
  logic             fill_buf;

  pp_skew_buffer #(.DW(DW), .M(M), .P(P), .B(B), .W(W), .RD_LAT(1)) dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit ended = 0;

  logic [DW-1:0] shadow [2][M];
  bit            cbuf = 1'b1;          // store the compute side reads
  logic [P-1:0]  exp_v = '0;
  logic [DW-1:0] exp_d [P];

  function automatic logic [DW-1:0] val(int g, int a);
    return DW'(g * 1000 + a * 37 + 5);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // One pipelined read cycle: check the previous request, then issue a new one.
  task automatic rd_step(string req, logic [P-1:0] en, logic [P*AW-1:0] addrs);
    @(negedge clk);
    for (int k = 0; k < P; k++) begin
      check({req, " valid"}, 32'(rd_valid[k]), 32'(exp_v[k]));
      if (exp_v[k]) check({req, " data"}, 32'(rd_data[k*DW +: DW]), 32'(exp_d[k]));
    end
    rd_en   = en;
    rd_addr = addrs;
    exp_v   = en;
    for (int k = 0; k < P; k++)
      exp_d[k] = shadow[cbuf][rd_addr[k*AW +: AW]];
  endtask

  task automatic wr_beat(int a, int g);
    int base;
    @(negedge clk);
    base     = a & ~(W - 1);
    wr_valid = 1'b1;
    wr_addr  = AW'(a);
    for (int j = 0; j < W; j++) wr_data[j*DW +: DW] = val(g, base + j);
    check("R3 wr_ready", 32'(wr_ready), 32'd1);
    for (int j = 0; j < W; j++) shadow[fill_buf][base + j] = val(g, base + j);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic fill_store(int g);
    for (int i = 0; i < M / W; i++) begin
      // Odd addresses on some beats: the low bits must be ignored (R3).
      wr_beat(i * W + ((i % 3 == 1) ? 1 : 0), g);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    for (int x = 0; x < 2; x++)
      for (int a = 0; a < M; a++) shadow[x][a] = '0;
    for (int k = 0; k < P; k++) exp_d[k] = '0;

    repeat (3) @(negedge clk);
    check("R10 fill_buf", 32'(fill_buf), 0);
    check("R10 busy", 32'(busy), 0);
    check("R10 wr_ready", 32'(wr_ready), 1);
    check("R10 rd_valid", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 fill_buf after reset", 32'(fill_buf), 0);

    // Fill store 0 (R1, R2, R3).
    fill_store(1);

    // R8: fill_done locks the write side; an offered beat is dropped.
    pulse(fill_done);
    check("R8 wr_ready low", 32'(wr_ready), 0);
    wr_valid = 1'b1;
    wr_addr  = '0;
    wr_data  = {W{16'hDEAD}};
    @(negedge clk);
    check("R8 wr_ready still low", 32'(wr_ready), 0);
    wr_valid = 1'b0;

    // R9: swap waits for calc_done.
    pulse(swap_req);
    check("R9 busy after request", 32'(busy), 1);
    repeat (3) @(negedge clk);
    check("R9 held fill_buf", 32'(fill_buf), 0);
    check("R9 held busy", 32'(busy), 1);
    @(negedge clk);
    calc_done = 1'b1;
    @(negedge clk);
    calc_done = 1'b0;
    check("R9 not yet swapped", 32'(fill_buf), 0);
    check("R9 busy before swap", 32'(busy), 1);
    @(negedge clk);
    check("R9 swapped fill_buf", 32'(fill_buf), 1);
    check("R9 busy cleared", 32'(busy), 0);
    check("R9 wr_ready restored", 32'(wr_ready), 1);
    cbuf = 1'b0;

    // R4: row order sweep over store 0.
    for (int r = 0; r < M / P; r++) begin
      logic [P*AW-1:0] ad;
      for (int k = 0; k < P; k++) ad[k*AW +: AW] = AW'(r * P + k);
      rd_step("R4 row", '1, ad);
    end
    // R5: stride order sweep.
    for (int c = 0; c + P <= M / B; c++)
      for (int o = 0; o < B; o++) begin
        logic [P*AW-1:0] ad;
        for (int k = 0; k < P; k++) ad[k*AW +: AW] = AW'(o + (c + k) * B);
        rd_step("R5 stride", '1, ad);
      end
    // R6/R7: one port at a time, scattered addresses, back to back.
    for (int i = 0; i < 4 * M; i++) begin
      logic [P*AW-1:0] ad;
      logic [P-1:0] en;
      ad = '0;
      en = '0;
      en[i % P] = 1'b1;
      ad[(i % P)*AW +: AW] = AW'((i * 23 + 11) % M);
      rd_step("R6 scattered", en, ad);
    end
    rd_step("R7 drain", '0, '0);
    rd_step("R7 idle", '0, '0);

    // R1: fill store 1 while store 0 stays intact.
    fill_store(2);
    for (int r = 0; r < M / P; r++) begin
      logic [P*AW-1:0] ad;
      for (int k = 0; k < P; k++) ad[k*AW +: AW] = AW'(r * P + k);
      rd_step("R1 isolation", '1, ad);
    end
    rd_step("R1 drain", '0, '0);

    // R9: both done first, then swap on the next edge without busy.
    pulse(fill_done);
    pulse(calc_done);
    @(negedge clk);
    swap_req = 1'b1;
    check("R9 pre-swap fill_buf", 32'(fill_buf), 1);
    @(negedge clk);
    swap_req = 1'b0;
    check("R9 immediate swap", 32'(fill_buf), 0);
    check("R9 immediate busy", 32'(busy), 0);
    cbuf = 1'b1;

    // R2/R4: store 1 holds the second fill at every address.
    for (int r = 0; r < M / P; r++) begin
      logic [P*AW-1:0] ad;
      for (int k = 0; k < P; k++) ad[k*AW +: AW] = AW'(r * P + k);
      rd_step("R2 store1 rows", '1, ad);
    end
    rd_step("R7 drain", '0, '0);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule